// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block is the host end of a two-wire serial debug link. It generates the link clock and drives the data line. The bidirectional pad sits outside the block. The block provides an output value and an output enable, and it receives the pad's input value. Each command carries out one complete operation:

- **Transfer.** An 8-bit request, a turnaround slot, a 3-bit acknowledge, and then a 32-bit word with parity. The word moves in the direction that the request names.
- **Line reset.** A run of clock slots with the line held high.
- **Idle burst.** A run of clock slots with the line held low.

All fields go out least significant bit first. Every transfer ends with a fixed run of low idle slots, so the target can finish the operation. The engine accepts no new command until those slots are complete.

Commands use a valid/ready handshake. `cmd_ready` is high only while the engine is at rest, and a command is taken on the clock where `cmd_valid` and `cmd_ready` are both high. The command fields must be stable in that cycle. The response is a single-cycle `rsp_valid` pulse with no back-pressure. The response fields hold their value until the next response. `clk_div` must stay stable while a command runs.

A slot is one link clock period, low half then high half. The host changes the line only on falling link clock edges. It samples target data on rising edges. Each half-period lasts `clk_div + 1` system clocks.

Top module: `swd_host`

## Requirements
- R1: The request goes out in slots 0 to 7, one bit per slot, in this order: 1, `cmd_apndp`, `cmd_rnw` (1 = read), `cmd_addr[0]`, `cmd_addr[1]`, parity, 0, 1.
- R2: The request parity bit is 1 exactly when `cmd_apndp`, `cmd_rnw` and `cmd_addr[1:0]` hold an odd number of ones.
- R3: In slot 8 (turnaround) and in acknowledge slots 9 to 11, `swdio_oe` is low. The line value sampled in slot 9+i becomes bit i of the acknowledge code.
- R4: For a write that receives acknowledge 3'b001 (OK), slot 12 is a released turnaround. Slots 13 to 44 then drive `cmd_wdata` LSB first, and slot 45 drives the word's odd parity.
- R5: For a read that receives OK, slots 12 to 43 sample the word LSB first and slot 44 samples its parity. Slot 45 is a released turnaround. `rsp_rdata` returns the word, and `rsp_par_err` is set when the sampled parity differs from the word's odd parity.
- R6: For any code other than OK (WAIT = 3'b010, FAULT = 3'b100, or others), the data phase is skipped. Slot 12 is a released turnaround, and the transfer lasts 21 slots. `rsp_rdata` is 0 and `rsp_par_err` is 0.
- R7: `rsp_ack` reports the sampled code. `rsp_proto_err` is 1 exactly when the code is none of 3'b001, 3'b010 or 3'b100.
- R8: Every transfer ends with TAIL_SLOTS (default 8) slots in which the host drives 0. An OK transfer therefore lasts 54 slots in total.
- R9: Command code 1 is a line reset: LRST_SLOTS (default 50) slots with the host driving 1.
- R10: Command codes 2 and 3 are an idle burst: IDLE_SLOTS (default 8) slots with the host driving 0. Code 0 is a transfer.
- R11: `swclk` rests high and each of its half-periods lasts `clk_div + 1` clocks. `swdio_out` and `swdio_oe` change only together with a falling `swclk`.
- R12: After reset, `cmd_ready` is 1, `swclk` is 1, `swdio_oe` is 1 and `swdio_out` is 0. `cmd_ready` drops for the whole command. `rsp_valid` pulses for one cycle on the last rising edge of the command, and `cmd_ready` is high again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIVW | Half-period length minus one, in clocks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine at rest, command can be taken |
| cmd_op | input | 2 | 0 transfer, 1 line reset, 2 or 3 idle burst |
| cmd_apndp | input | 1 | Request port-select flag |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits (bit 0 sent first) |
| cmd_wdata | input | 32 | Word to write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ack | output | 3 | Acknowledge code as sampled, first bit in bit 0 |
| rsp_rdata | output | 32 | Word read |
| rsp_par_err | output | 1 | Read parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge code not a valid response |
| swclk | output | 1 | Link clock |
| swdio_out | output | 1 | Value driven onto the data line |
| swdio_oe | output | 1 | Host drives the data line when 1 |
| swdio_in | input | 1 | Value seen on the data line |

## Verification
All sixteen combinations of port flag, direction and address are sent with an OK acknowledge, each with a distinct data word. This separates errors in request bit order and parity from errors in data bit order and direction handling. All eight acknowledge codes are then applied to both a read and a write. This separates the data-phase branch, the skipped-phase branch and protocol-error reporting. All-zero and all-one words, a corrupted read parity, three divider settings, and the line reset and idle commands cover the remaining boundaries.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [3:0] {
    PH_REST, PH_START, PH_REQ, PH_TRN1, PH_ACK, PH_TRN2,
    PH_WDAT, PH_RDAT, PH_TRN3, PH_TAIL, PH_LRST, PH_IDLE
  } phase_e;

  localparam logic [1:0] OP_XFER = 2'd0;
  localparam logic [1:0] OP_LRST = 2'd1;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  // bit 0 leaves the host first
  function automatic logic [7:0] build_req(logic ap, logic rnw, logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_edge_gen.sv
module swd_edge_gen #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            swclk,
  output logic            fall,
  output logic            rise
);
  logic [DIVW-1:0] cnt;
  logic            sclk;
  logic            term;

  assign term  = run && (cnt == div);
  assign fall  = term && sclk;
  assign rise  = term && !sclk;
  assign swclk = sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
    end else if (term) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11
  swclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk);

endmodule

// File: rtl/swd_frame_fsm.sv
module swd_frame_fsm
  import swd_host_pkg::*;
#(
  parameter int TAIL_SLOTS = 8,
  parameter int LRST_SLOTS = 50,
  parameter int IDLE_SLOTS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fall,
  input  logic        rise,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic        cmd_apndp,
  input  logic        cmd_rnw,
  input  logic [1:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  output logic        rsp_valid,
  output logic [2:0]  rsp_ack,
  output logic [31:0] rsp_rdata,
  output logic        rsp_par_err,
  output logic        rsp_proto_err,
  output logic        run,
  output logic        dout,
  output logic        oe,
  input  logic        din
);
  localparam int M1   = (LRST_SLOTS > IDLE_SLOTS) ? LRST_SLOTS : IDLE_SLOTS;
  localparam int M2   = (M1 > TAIL_SLOTS) ? M1 : TAIL_SLOTS;
  localparam int MAXS = (M2 > 33) ? M2 : 33;
  localparam int CW   = $clog2(MAXS + 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_SLOTS - 1);
  localparam logic [CW-1:0] LRST_LAST = CW'(LRST_SLOTS - 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_SLOTS - 1);
  localparam logic [CW-1:0] DPAR      = CW'(32);

  phase_e      ph;
  logic [CW-1:0] cnt;
  logic [1:0]  op_q;
  logic        rnw_q;
  logic [7:0]  req_q;
  logic [31:0] wd_q, rd_q;
  logic [2:0]  ack_q;
  logic        rpar_q;
  logic        ack_ok, ack_known, finish;
  logic [4:0]  nxt_bit;

  assign run       = (ph != PH_REST);
  assign cmd_ready = (ph == PH_REST);
  assign ack_ok    = (ack_q == ACK_OK);
  assign ack_known = (ack_q == ACK_OK) || (ack_q == ACK_WAIT) || (ack_q == ACK_FAULT);
  assign nxt_bit   = cnt[4:0] + 5'd1;
  assign finish    = rise && (((ph == PH_TAIL) && (cnt == TAIL_LAST)) ||
                              ((ph == PH_LRST) && (cnt == LRST_LAST)) ||
                              ((ph == PH_IDLE) && (cnt == IDLE_LAST)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_REST; cnt <= '0; op_q <= '0; rnw_q <= 1'b0; req_q <= '0;
      wd_q <= '0; rd_q <= '0; ack_q <= '0; rpar_q <= 1'b0;
      oe <= 1'b1; dout <= 1'b0;
      rsp_valid <= 1'b0; rsp_ack <= '0; rsp_rdata <= '0;
      rsp_par_err <= 1'b0; rsp_proto_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (ph == PH_REST) begin
        if (cmd_valid) begin
          ph    <= PH_START;
          op_q  <= cmd_op;
          rnw_q <= cmd_rnw;
          req_q <= build_req(cmd_apndp, cmd_rnw, cmd_addr);
          wd_q  <= cmd_wdata;
        end
      end else if (finish) begin
        ph            <= PH_REST;
        rsp_valid     <= 1'b1;
        rsp_ack       <= (op_q == OP_XFER) ? ack_q : 3'b000;
        rsp_rdata     <= (op_q == OP_XFER && rnw_q && ack_ok) ? rd_q : 32'd0;
        rsp_par_err   <= (op_q == OP_XFER) && rnw_q && ack_ok && ((^rd_q) != rpar_q);
        rsp_proto_err <= (op_q == OP_XFER) && !ack_known;
      end else if (fall) begin
        unique case (ph)
          PH_START: begin
            cnt <= '0; oe <= 1'b1;
            if (op_q == OP_XFER) begin ph <= PH_REQ;  dout <= req_q[0]; end
            else if (op_q == OP_LRST) begin ph <= PH_LRST; dout <= 1'b1; end
            else begin ph <= PH_IDLE; dout <= 1'b0; end
          end
          PH_REQ: begin
            if (cnt == CW'(7)) begin ph <= PH_TRN1; oe <= 1'b0; end
            else begin cnt <= cnt + 1'b1; dout <= req_q[nxt_bit[2:0]]; end
          end
          PH_TRN1: begin ph <= PH_ACK; cnt <= '0; end
          PH_ACK: begin
            cnt <= '0;
            if (cnt == CW'(2)) ph <= (ack_ok && rnw_q) ? PH_RDAT : PH_TRN2;
            else cnt <= cnt + 1'b1;
          end
          PH_TRN2: begin
            cnt <= '0; oe <= 1'b1;
            if (ack_ok) begin ph <= PH_WDAT; dout <= wd_q[0]; end
            else begin ph <= PH_TAIL; dout <= 1'b0; end
          end
          PH_WDAT: begin
            if (cnt == DPAR) begin ph <= PH_TAIL; cnt <= '0; dout <= 1'b0; end
            else begin
              cnt  <= cnt + 1'b1;
              dout <= (cnt == CW'(31)) ? ^wd_q : wd_q[nxt_bit];
            end
          end
          PH_RDAT: begin
            if (cnt == DPAR) ph <= PH_TRN3;
            else cnt <= cnt + 1'b1;
          end
          PH_TRN3: begin ph <= PH_TAIL; cnt <= '0; oe <= 1'b1; dout <= 1'b0; end
          default: cnt <= cnt + 1'b1;
        endcase
      end else if (rise) begin
        if (ph == PH_ACK) ack_q[cnt[1:0]] <= din;
        if (ph == PH_RDAT) begin
          if (cnt == DPAR) rpar_q <= din;
          else rd_q[cnt[4:0]] <= din;
        end
      end
    end
  end

  // R11
  pin_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(oe) || !$stable(dout)) |-> $past(fall));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ACK || ph == PH_TRN1) |-> !oe);

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_proto_err) |-> (!rsp_par_err && rsp_ack != ACK_OK));

endmodule

// File: rtl/swd_host.sv
module swd_host
  import swd_host_pkg::*;
#(
  parameter int DIVW       = 4,
  parameter int TAIL_SLOTS = 8,
  parameter int LRST_SLOTS = 50,
  parameter int IDLE_SLOTS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] clk_div,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_apndp,
  input  logic            cmd_rnw,
  input  logic [1:0]      cmd_addr,
  input  logic [31:0]     cmd_wdata,
  output logic            rsp_valid,
  output logic [2:0]      rsp_ack,
  output logic [31:0]     rsp_rdata,
  output logic            rsp_par_err,
  output logic            rsp_proto_err,
  output logic            swclk,
  output logic            swdio_out,
  output logic            swdio_oe,
  input  logic            swdio_in
);
  logic run, fall, rise;

  swd_edge_gen #(.DIVW(DIVW)) u_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div),
    .swclk(swclk), .fall(fall), .rise(rise)
  );

  swd_frame_fsm #(
    .TAIL_SLOTS(TAIL_SLOTS), .LRST_SLOTS(LRST_SLOTS), .IDLE_SLOTS(IDLE_SLOTS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_par_err(rsp_par_err),
    .rsp_proto_err(rsp_proto_err), .run(run), .dout(swdio_out),
    .oe(swdio_oe), .din(swdio_in)
  );

endmodule

// File: tb/test_swd_host.sv
module test_swd_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  clk_div = 4'd0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_apndp = 1'b0, cmd_rnw = 1'b0;
  logic [1:0]  cmd_addr = 2'd0;
  logic [31:0] cmd_wdata = 32'd0;
  logic        rsp_valid;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        rsp_par_err, rsp_proto_err;
  logic        swclk, swdio_out, swdio_oe;
  logic        swdio_in = 1'b1;

  always #4 clk = ~clk;

  swd_host i_swd_host (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_par_err(rsp_par_err),
    .rsp_proto_err(rsp_proto_err), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  int checks = 0, errors = 0;
  logic tgt [0:63];
  logic rec_oe [0:63];
  logic rec_out [0:63];
  logic exp_oe [0:63];
  logic exp_out [0:63];
  int slot = -1;
  logic prev_sw = 1'b1;
  int halfcnt = 0;
  bit hp_seen = 0;
  int hp_bad = 0;
  logic [2:0]  got_ack;
  logic [31:0] got_rd;
  logic        got_pe, got_pr, got_pulse2, got_ready;

  // link monitor and target model
  always @(negedge clk) begin
    halfcnt++;
    if (swclk !== prev_sw) begin
      if (hp_seen && halfcnt != int'(clk_div) + 1) hp_bad++;
      hp_seen = 1; halfcnt = 0;
      if (!swclk) begin
        slot++;
        if (slot < 64) swdio_in = tgt[slot];
      end else if (slot >= 0 && slot < 64) begin
        rec_oe[slot]  = swdio_oe;
        rec_out[slot] = swdio_out;
      end
    end
    prev_sw = swclk;
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic run_cmd(input logic [1:0] op);
    for (int k = 0; k < 64; k++) begin rec_oe[k] = 1'bx; rec_out[k] = 1'bx; end
    slot = -1; hp_seen = 0; hp_bad = 0;
    @(negedge clk);
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got_ack = rsp_ack; got_rd = rsp_rdata; got_pe = rsp_par_err;
    got_pr = rsp_proto_err; got_ready = cmd_ready;
    @(negedge clk);
    got_pulse2 = rsp_valid;
  endtask

  task automatic cmp_slots(input int lo, input int hi, input string tag);
    int bad = -1;
    for (int k = lo; k <= hi; k++)
      if (bad < 0 && (rec_oe[k] !== exp_oe[k] || (exp_oe[k] && rec_out[k] !== exp_out[k])))
        bad = k;
    if (bad < 0) chk(1, tag);
    else chk(0, $sformatf("%s slot %0d oe/out actual %b/%b expected %b/%b", tag, bad,
                          rec_oe[bad], rec_out[bad], exp_oe[bad], exp_out[bad]));
  endtask

  task automatic xfer(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd,
                      input logic [2:0] ack, input logic [31:0] rd, input bit badp);
    logic [7:0] req;
    bit ok;
    int total;
    ok  = (ack == 3'b001);
    req = {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
    for (int k = 0; k < 64; k++) begin tgt[k] = 1'b1; exp_oe[k] = 1'b0; exp_out[k] = 1'b0; end
    for (int k = 0; k < 8; k++) begin exp_oe[k] = 1'b1; exp_out[k] = req[k]; end
    for (int k = 0; k < 3; k++) tgt[9+k] = ack[k];
    if (ok && rnw) begin
      for (int k = 0; k < 32; k++) tgt[12+k] = rd[k];
      tgt[44] = (^rd) ^ badp;
    end
    if (ok && !rnw) for (int k = 0; k < 33; k++) begin
      exp_oe[13+k] = 1'b1; exp_out[13+k] = (k == 32) ? ^wd : wd[k];
    end
    total = ok ? 54 : 21;
    for (int k = total - 8; k < total; k++) begin exp_oe[k] = 1'b1; exp_out[k] = 1'b0; end
    cmd_apndp = ap; cmd_rnw = rnw; cmd_addr = a; cmd_wdata = wd;
    run_cmd(2'd0);
    cmp_slots(0, 7, "R1 R2 request frame");
    cmp_slots(8, 11, "R3 turnaround and ack release");
    cmp_slots(12, total - 9, ok ? (rnw ? "R5 read data phase" : "R4 write data phase")
                                : "R6 skipped data phase");
    cmp_slots(total - 8, total - 1, "R8 trailing idle");
    chk(slot + 1 == total, $sformatf("R8 slot count actual %0d expected %0d", slot + 1, total));
    chk(hp_bad == 0, $sformatf("R11 half-period errors actual %0d expected 0", hp_bad));
    chk(got_ack == ack, $sformatf("R7 ack actual %b expected %b", got_ack, ack));
    chk(got_pr == !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100),
        $sformatf("R7 proto_err actual %b for ack %b", got_pr, ack));
    chk(got_rd == ((ok && rnw) ? rd : 32'd0),
        $sformatf("R5 R6 rdata actual %h expected %h", got_rd, (ok && rnw) ? rd : 32'd0));
    chk(got_pe == (ok && rnw && badp),
        $sformatf("R5 par_err actual %b expected %b", got_pe, ok && rnw && badp));
    chk(got_ready && !got_pulse2,
        $sformatf("R12 ready/pulse actual %b/%b expected 1/0", got_ready, got_pulse2));
  endtask

  task automatic fill_cmd(input logic [1:0] op, input logic val, input int n, input string tag);
    for (int k = 0; k < 64; k++) begin tgt[k] = 1'b1; exp_oe[k] = 1'b1; exp_out[k] = val; end
    run_cmd(op);
    cmp_slots(0, n - 1, tag);
    chk(slot + 1 == n, $sformatf("%s slot count actual %0d expected %0d", tag, slot + 1, n));
    chk(got_ack == 3'b000 && !got_pr && !got_pe,
        $sformatf("%s response actual %b/%b/%b expected 000/0/0", tag, got_ack, got_pr, got_pe));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && swclk && swdio_oe && !swdio_out && !rsp_valid,
        $sformatf("R12 reset state actual rdy%b clk%b oe%b out%b v%b expected 1 1 1 0 0",
                  cmd_ready, swclk, swdio_oe, swdio_out, rsp_valid));
    // request sweep, writes and reads with OK
    for (int i = 0; i < 16; i++) begin
      xfer(i[0], i[1], i[3:2], (32'h1 << (2*i)) ^ (32'h0101_0101 * i), 3'b001, 32'd0, 0);
      xfer(i[0], ~i[1], i[3:2], 32'd0, 3'b001, 32'hC3A5_0F00 ^ (32'h8000_0001 << i), 0);
    end
    clk_div = 4'd1;
    // all acknowledge codes, both directions
    for (int c = 0; c < 8; c++) begin
      xfer(1, 0, 2'd1, 32'hDEAD_BEEF, c[2:0], 32'd0, 0);
      xfer(0, 1, 2'd2, 32'd0, c[2:0], 32'h1234_5678, 0);
    end
    // boundary words and corrupted parity
    xfer(1, 0, 2'd3, 32'h0000_0000, 3'b001, 32'd0, 0);
    xfer(1, 0, 2'd3, 32'hFFFF_FFFF, 3'b001, 32'd0, 0);
    xfer(1, 1, 2'd3, 32'd0, 3'b001, 32'hFFFF_FFFF, 0);
    xfer(1, 1, 2'd3, 32'd0, 3'b001, 32'h0000_0000, 1);
    xfer(0, 1, 2'd0, 32'd0, 3'b001, 32'h8000_0000, 1);
    clk_div = 4'd3;
    xfer(0, 0, 2'd2, 32'h5A5A_F00F, 3'b001, 32'd0, 0);
    xfer(0, 1, 2'd1, 32'd0, 3'b001, 32'h0F0F_1357, 0);
    chk(hp_bad == 0, "R11 divider 3 half-periods");
    fill_cmd(2'd1, 1'b1, 50, "R9 line reset");
    fill_cmd(2'd2, 1'b0, 8, "R10 idle burst code 2");
    clk_div = 4'd0;
    fill_cmd(2'd3, 1'b0, 8, "R10 idle burst code 3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule